// File: doc/BRIEF.md
# Latching Comparator Status Conditioner

This block sits between an independent comparator and the two places its result is seen: an open-drain status pin and a status bit that host software reads. The raw comparator level is first brought into the clock domain by a multi-flop synchroniser. The conditioned level then drives the pin, either passed straight through or held low once a low has been seen, depending on a host control bit.

Host software releases a held low by taking the control bit from 1 to 0. Taking it back to 1 arms the hold again. Separately, when a profile enable is set, each high-to-low trip of the synchronised comparator sets a sticky status flag. The flag stays at 1 until a host read strobe clears it. A trip that lands on the same cycle as a read wins over the read, so no event is dropped.

Top module: `cmplat_top`

## Requirements
- R1: After reset, with the comparator input high, `pin_level` is 1 and `stat_flag` is 0.
- R2: `cmp_raw` reaches `pin_level` through exactly `SYNC_STAGES` (default 2) clock edges. A change applied between edges is not visible after one edge and is visible after the second.
- R3: With `latch_en` at 0, `pin_level` follows the synchronised comparator level in both directions.
- R4: With `latch_en` at 1, a low on the synchronised comparator drives `pin_level` to 0. It stays 0 after the comparator returns high.
- R5: A 1-to-0 transition of `latch_en` releases a held low. From then on `pin_level` follows the comparator.
- R6: A 0-to-1 transition of `latch_en` while the comparator is high leaves `pin_level` at 1. Only a later low is captured.
- R7: With `prof_en` at 1, a high-to-low transition of the synchronised comparator sets `stat_flag`. The flag stays 1 while no read occurs.
- R8: A one-cycle pulse on `stat_rd` clears `stat_flag` on the next edge when no trip coincides.
- R9: A trip on the same cycle as `stat_rd` leaves `stat_flag` at 1.
- R10: With `prof_en` at 0, a trip does not set `stat_flag`, and `pin_level` behaves as in R3 and R4.
- R11: A comparator level held low produces one trip only. Once that trip's flag is read, the flag stays 0 until a new high-to-low transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | 1 | Asynchronous comparator output, 1 = not tripped |
| latch_en | input | 1 | Host control: hold a low on the pin |
| prof_en | input | 1 | Host control: comparator trips feed the status flag |
| stat_rd | input | 1 | One-cycle strobe marking a host read of the status |
| pin_level | output | 1 | Level for the open-drain pin, 0 = pull low |
| stat_flag | output | 1 | Sticky trip status |

## Verification
The bench sweeps every combination of the two enables against a short low pulse. It checks whether the pin holds and whether the flag sets. A design that ignored one enable, or coupled the flag to the hold, fails that sweep.

A read strobe is held across a trip and the cycles in which the flag reads 1 are counted. If the read had priority over the trip, the count would be zero instead of one.

Re-arming is checked with the comparator high, to catch a hold that sets without a new low. A long held low is checked to catch level-triggered flag setting, which would re-set the flag after every read. The synchroniser latency is sampled one edge early to catch a missing stage.

// File: rtl/cmplat_pkg.sv
`timescale 1ns/1ps
package cmplat_pkg;
   localparam int unsigned MIN_SYNC = 2;
   typedef struct packed {
      logic level;
      logic fall;
   } cmp_view_t;
endpackage

// File: rtl/cmplat_sync.sv
`timescale 1ns/1ps
module cmplat_sync
   import cmplat_pkg::*;
#(
   parameter int unsigned STAGES = 2,
   parameter logic        IDLE   = 1'b1
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      raw_i,
   output cmp_view_t view_o
);
   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= IDLE;
            else        chain_q[0] <= raw_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[gi] <= IDLE;
            else        chain_q[gi] <= chain_q[gi-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE;
      else        prev_q <= chain_q[LAST];
   end

   always_comb begin
      view_o.level = chain_q[LAST];
      view_o.fall  = prev_q & ~chain_q[LAST];
   end

   // a trip is a single-cycle event
   assert_single_trip_R11: assert property (@(posedge clk) disable iff (!rst_n)
      view_o.fall |=> !view_o.fall);
endmodule

// File: rtl/cmplat_hold.sv
`timescale 1ns/1ps
module cmplat_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   input  logic latch_en,
   output logic pin_o
);
   logic en_q;
   logic held_q;
   logic release_w;

   assign release_w = en_q & ~latch_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         held_q <= 1'b0;
      end else begin
         en_q <= latch_en;
         if (release_w)                held_q <= 1'b0;
         else if (latch_en && !level_i) held_q <= 1'b1;
      end
   end

   assign pin_o = level_i & ~held_q;

   assert_hold_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && latch_en) |=> (held_q || !latch_en));
   assert_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!latch_en) && !latch_en) |-> !held_q);
   assert_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !held_q |-> (pin_o == level_i));
endmodule

// File: rtl/cmplat_flag.sv
`timescale 1ns/1ps
module cmplat_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic fall_i,
   input  logic prof_en,
   input  logic rd_i,
   output logic flag_o
);
   logic set_w;
   assign set_w = fall_i & prof_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_w) flag_o <= 1'b1;
      else if (rd_i)  flag_o <= 1'b0;
   end

   assert_trip_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_i && prof_en) |=> flag_o);
   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !rd_i) |=> flag_o);
   assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !(fall_i && prof_en)) |=> !flag_o);
   assert_no_profile_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o && !prof_en) |=> !flag_o);
endmodule

// File: rtl/cmplat_top.sv
`timescale 1ns/1ps
module cmplat_top
   import cmplat_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic cmp_raw,
   input  logic latch_en,
   input  logic prof_en,
   input  logic stat_rd,
   output logic pin_level,
   output logic stat_flag
);
   if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
      $error("cmplat_top: SYNC_STAGES must be at least 2");
   end

   cmp_view_t view;

   cmplat_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_i(cmp_raw), .view_o(view));

   cmplat_hold u_hold (
      .clk(clk), .rst_n(rst_n), .level_i(view.level),
      .latch_en(latch_en), .pin_o(pin_level));

   cmplat_flag u_flag (
      .clk(clk), .rst_n(rst_n), .fall_i(view.fall),
      .prof_en(prof_en), .rd_i(stat_rd), .flag_o(stat_flag));

   assert_trip_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (view.fall && prof_en && stat_rd) |=> stat_flag);
endmodule

// File: tb/sim_cmplat_top.sv
`timescale 1ns/1ps
module sim_cmplat_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmp_raw = 1'b1, latch_en = 1'b0, prof_en = 1'b0, stat_rd = 1'b0;
   logic pin_level, stat_flag;
   int   n_run = 0, n_fail = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   cmplat_top #(.SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .latch_en(latch_en),
      .prof_en(prof_en), .stat_rd(stat_rd), .pin_level(pin_level),
      .stat_flag(stat_flag));

   task automatic step(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(logic act, logic exp, string req);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic host_read();
      stat_rd = 1'b1; step(1); stat_rd = 1'b0;
   endtask

   task automatic pulse_low(int n);
      cmp_raw = 1'b0; step(n); cmp_raw = 1'b1; step(5);
   endtask

   initial begin
      int hi_cnt;
      step(3);
      rst_n = 1'b1;
      step(1);
      check(pin_level, 1'b1, "R1 pin");
      check(stat_flag, 1'b0, "R1 flag");

      // R2 latency: two edges
      cmp_raw = 1'b0; step(1);
      check(pin_level, 1'b1, "R2 one edge");
      step(1);
      check(pin_level, 1'b0, "R2 two edges");
      cmp_raw = 1'b1; step(1);
      check(pin_level, 1'b0, "R2 rise one edge");
      step(1);
      check(pin_level, 1'b1, "R2 rise two edges");
      step(3);

      // sweep both enables
      for (int le = 0; le < 2; le++) begin
         for (int pe = 0; pe < 2; pe++) begin
            latch_en = le[0]; prof_en = pe[0];
            host_read(); step(2);
            cmp_raw = 1'b0; step(3);
            check(pin_level, 1'b0, "R3/R4 low seen");
            cmp_raw = 1'b1; step(5);
            check(pin_level, ~le[0], le ? "R4 hold" : "R3 follow");
            check(stat_flag, pe[0], pe ? "R7 set" : "R10 no set");
            step(4);
            check(stat_flag, pe[0], pe ? "R7 sticky" : "R10 stays 0");
            host_read(); step(1);
            check(stat_flag, 1'b0, "R8 cleared");
            latch_en = 1'b0; step(2);
            check(pin_level, 1'b1, "R5 released");
            cmp_raw = 1'b0; step(3);
            check(pin_level, 1'b0, "R5 follows low");
            cmp_raw = 1'b1; step(3);
            check(pin_level, 1'b1, "R5 follows high");
            host_read(); step(1);
         end
      end

      // R6 re-arm while high
      prof_en = 1'b0; latch_en = 1'b1;
      pulse_low(3);
      check(pin_level, 1'b0, "R6 first capture");
      latch_en = 1'b0; step(2);
      latch_en = 1'b1; step(5);
      check(pin_level, 1'b1, "R6 re-arm no capture");
      pulse_low(3);
      check(pin_level, 1'b0, "R6 new low captured");
      latch_en = 1'b0; step(2);

      // R9 read held across trip
      prof_en = 1'b1; stat_rd = 1'b1; step(1);
      cmp_raw = 1'b0;
      hi_cnt = 0;
      for (int i = 0; i < 8; i++) begin
         step(1);
         if (stat_flag) hi_cnt++;
      end
      stat_rd = 1'b0;
      check(hi_cnt == 1, 1'b1, "R9 trip beats read");

      // R11 held low gives one trip
      step(2);
      check(stat_flag, 1'b0, "R11 after read");
      step(10);
      check(stat_flag, 1'b0, "R11 held low no retrigger");
      cmp_raw = 1'b1; step(4);
      cmp_raw = 1'b0; step(4);
      check(stat_flag, 1'b1, "R11 new fall sets");
      cmp_raw = 1'b1; step(2);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule